// File: doc/BRIEF.md
# UART Baud Clock Selector

This block produces the sampling strobes for one UART channel: a receive strobe and a transmit strobe, each a one-cycle enable on the fabric clock. The fabric clock is a fixed 3.6864 MHz reference. Each direction has its own 4-bit select code. Codes 0 to 13 pick an internal rate, made by dividing the reference down to a strobe at 16 times the bit rate. Codes 14 and 15 instead take an external clock pin for that direction. The pin is synchronised, and each rising edge becomes one strobe.

A per-direction flag tells the downstream shifter whether the strobe is a 1x bit clock (code 15) or a 16x oversampling clock (every other code). Register decoding and the shift registers themselves sit outside this block.

Each direction is controlled by a small state machine with three named states:
- `ST_LOAD` reloads the divider.
- `ST_DIV` emits strobes from the divider.
- `ST_PIN` emits strobes from the synchronised pin.

Transitions: reset or any change of the select code goes to `ST_LOAD`. From `ST_LOAD`, an internal code (0 to 13) goes to `ST_DIV` and a pin code (14 or 15) goes to `ST_PIN`. `ST_DIV` and `ST_PIN` hold until the code changes.

Top module: `baud_clk_sel`

## Requirements
- R1: While `rst` is high, both strobes and both 1x flags are low, whatever the select codes are.
- R2: Internal codes map to baud rates as follows: 0=300, 1=600, 2=1200, 3=2400, 4=4800, 5=9600, 6=19200, 7=38400, 8=110, 9=2000, 10=1800, 11=150, 12=75, 13=50. In steady state the strobe period is exactly D cycles, where D = round(3686400 / (16 * baud)).
- R3: Code 5 (9600 baud) gives D = 24, which is a 153.6 kHz strobe. Code 7 (38400 baud) gives D = 6, which is 614.4 kHz. Both rates are exact.
- R4: Inexact rates take the rounded divisor. Code 8 (110 baud) gives D = 2095 and code 9 (2000 baud) gives D = 115.
- R5: With receive code 14, one receive strobe follows each rising edge of `rx_ext`. The strobe is visible in the third clock cycle after the edge is first sampled. `rx_1x` stays low.
- R6: Code 15 produces the same pin-driven strobes as code 14, and the direction's 1x flag is high.
- R7: Transmit codes 14 and 15 use `tx_ext` only. Each pin affects only its own direction's strobe.
- R8: A 1x flag is high exactly when its direction's select code, as sampled on the previous clock edge, is 15.
- R9: After a select code changes, the old rate produces no strobe after the first cycle. In internal mode the first strobe of the new rate appears D+2 cycles after the edge that samples the new code.
- R10: The two directions run independently, each at its own code, at the same time.
- R11: Every strobe is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.6864 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_sel | input | 4 | Receive rate select code |
| tx_sel | input | 4 | Transmit rate select code |
| rx_ext | input | 1 | External receive clock pin (asynchronous) |
| tx_ext | input | 1 | External transmit clock pin (asynchronous) |
| rx_tick | output | 1 | Receive sampling strobe |
| tx_tick | output | 1 | Transmit sampling strobe |
| rx_1x | output | 1 | Receive strobe is a 1x bit clock |
| tx_1x | output | 1 | Transmit strobe is a 1x bit clock |

## Verification
A wrong divisor, or a counter that does not reload, shows within one strobe period. It appears as a strobe spacing other than D, or as a first strobe that comes early or late relative to the select change. Every internal code is therefore timed in both directions, three strobes deep. A broken synchroniser or edge detector shows within four cycles of a pin edge: as a missing, doubled or wide strobe, or as a strobe on the wrong direction. A stale select register shows on the very next cycle as a wrong 1x flag.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;

    localparam int unsigned SEL_W = 4;
    localparam int unsigned N_INT = 14;
    localparam logic [SEL_W-1:0] SEL_PIN16 = 4'hE;
    localparam logic [SEL_W-1:0] SEL_PIN1  = 4'hF;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_DIV  = 2'd1,
        ST_PIN  = 2'd2
    } src_state_t;

    // Baud rate assigned to each internal code.
    function automatic int unsigned code_baud(input logic [SEL_W-1:0] code);
        int unsigned b;
        unique case (code)
            4'd0:    b = 300;
            4'd1:    b = 600;
            4'd2:    b = 1200;
            4'd3:    b = 2400;
            4'd4:    b = 4800;
            4'd5:    b = 9600;
            4'd6:    b = 19200;
            4'd7:    b = 38400;
            4'd8:    b = 110;
            4'd9:    b = 2000;
            4'd10:   b = 1800;
            4'd11:   b = 150;
            4'd12:   b = 75;
            4'd13:   b = 50;
            default: b = 9600;
        endcase
        return b;
    endfunction

    // Rounded divisor from the reference to the 16x strobe.
    function automatic int unsigned code_divisor(input int unsigned ref_hz,
                                                 input logic [SEL_W-1:0] code);
        int unsigned b;
        b = code_baud(code);
        return ((ref_hz / 16) + (b / 2)) / b;
    endfunction

endpackage

// File: rtl/baud_div.sv
module baud_div #(
    parameter int unsigned DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             hit
);

    logic [DIV_W-1:0] cnt;

    assign hit = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= div - 1'b1;
        end else if (run) begin
            if (cnt == '0) begin
                cnt <= div - 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pin_rise.sv
module pin_rise #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Reset to ones so a pin held high through reset makes no edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/baud_dir.sv
module baud_dir
    import baud_sel_pkg::*;
#(
    parameter int unsigned REF_HZ      = 3686400,
    parameter int unsigned DIV_W       = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             pin,
    output logic             tick,
    output logic             mode_1x
);

    localparam int unsigned IDX_W = $clog2(N_INT);

    src_state_t       state_q;
    src_state_t       state_d;
    logic [SEL_W-1:0] sel_q;
    logic             sel_chg;
    logic             is_pin;
    logic             tick_q;
    logic             tick_d;
    logic             hit;
    logic             rise;
    logic [DIV_W-1:0] div_val;
    logic [DIV_W-1:0] div_tab [N_INT];

    for (genvar i = 0; i < N_INT; i++) begin : g_tab
        assign div_tab[i] = DIV_W'(code_divisor(REF_HZ, SEL_W'(i)));
    end

    always_comb begin
        if (sel_q < SEL_W'(N_INT)) begin
            div_val = div_tab[sel_q[IDX_W-1:0]];
        end else begin
            div_val = '0;
        end
    end

    assign sel_chg = (sel != sel_q);
    assign is_pin  = (sel_q >= SEL_PIN16);

    baud_div #(.DIV_W(DIV_W)) div_i (
        .clk  (clk),
        .rst  (rst),
        .load (state_q == ST_LOAD),
        .run  (state_q == ST_DIV),
        .div  (div_val),
        .hit  (hit)
    );

    pin_rise #(.SYNC_STAGES(SYNC_STAGES)) pin_i (
        .clk  (clk),
        .rst  (rst),
        .pin  (pin),
        .rise (rise)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            sel_q   <= '0;
            tick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel;
            tick_q  <= tick_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (sel_chg) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_LOAD: state_d = is_pin ? ST_PIN : ST_DIV;
                ST_DIV:  state_d = ST_DIV;
                ST_PIN:  state_d = ST_PIN;
                default: state_d = ST_LOAD;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_LOAD: tick_d = 1'b0;
            ST_DIV:  tick_d = hit;
            ST_PIN:  tick_d = rise;
            default: tick_d = 1'b0;
        endcase
    end

    assign tick    = tick_q;
    assign mode_1x = (sel_q == SEL_PIN1);

endmodule

// File: rtl/baud_clk_sel.sv
module baud_clk_sel
    import baud_sel_pkg::*;
#(
    parameter int unsigned REF_HZ      = 3686400,
    parameter int unsigned DIV_W       = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rx_sel,
    input  logic [3:0] tx_sel,
    input  logic       rx_ext,
    input  logic       tx_ext,
    output logic       rx_tick,
    output logic       tx_tick,
    output logic       rx_1x,
    output logic       tx_1x
);

    localparam int unsigned N_DIR = 2;

    logic [SEL_W-1:0] sel_a  [N_DIR];
    logic             pin_a  [N_DIR];
    logic             tick_a [N_DIR];
    logic             x1_a   [N_DIR];

    assign sel_a[0] = rx_sel;
    assign sel_a[1] = tx_sel;
    assign pin_a[0] = rx_ext;
    assign pin_a[1] = tx_ext;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        baud_dir #(
            .REF_HZ      (REF_HZ),
            .DIV_W       (DIV_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) dir_i (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel_a[d]),
            .pin     (pin_a[d]),
            .tick    (tick_a[d]),
            .mode_1x (x1_a[d])
        );
    end

    assign rx_tick = tick_a[0];
    assign tx_tick = tick_a[1];
    assign rx_1x   = x1_a[0];
    assign tx_1x   = x1_a[1];

endmodule

// File: rtl/baud_clk_sel_chk.sv
module baud_clk_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] rx_sel,
    input logic [3:0] tx_sel,
    input logic       rx_ext,
    input logic       tx_ext,
    input logic       rx_tick,
    input logic       tx_tick,
    input logic       rx_1x,
    input logic       tx_1x
);

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_tick |=> !rx_tick);                                        // R11
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_tick |=> !tx_tick);                                        // R11
    AST_RX_X1_CODE: assert property (@(posedge clk) disable iff (rst)
        rx_1x |-> ($past(rx_sel) == 4'hF));                           // R8
    AST_TX_X1_CODE: assert property (@(posedge clk) disable iff (rst)
        tx_1x |-> ($past(tx_sel) == 4'hF));                           // R8
    AST_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rx_sel != $past(rx_sel)) |-> ##2 !rx_tick);                  // R9
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tx_sel != $past(tx_sel)) |-> ##2 !tx_tick);                  // R9
    AST_RX_PIN_RISE: assert property (@(posedge clk) disable iff (rst)
        (rx_tick && rx_1x && $past(rx_1x)) |->
            ($past(rx_ext, 3) && !$past(rx_ext, 4)));                 // R6
    AST_TX_PIN_RISE: assert property (@(posedge clk) disable iff (rst)
        (tx_tick && tx_1x && $past(tx_1x)) |->
            ($past(tx_ext, 3) && !$past(tx_ext, 4)));                 // R6

endmodule

bind baud_clk_sel baud_clk_sel_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .rx_sel  (rx_sel),
    .tx_sel  (tx_sel),
    .rx_ext  (rx_ext),
    .tx_ext  (tx_ext),
    .rx_tick (rx_tick),
    .tx_tick (tx_tick),
    .rx_1x   (rx_1x),
    .tx_1x   (tx_1x)
);

// File: tb/baud_clk_sel_tb.sv
`timescale 1ns/1ps
module baud_clk_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rx_sel = 4'hF;
    logic [3:0] tx_sel = 4'hF;
    logic       rx_ext = 1'b0;
    logic       tx_ext = 1'b0;
    logic       rx_tick;
    logic       tx_tick;
    logic       rx_1x;
    logic       tx_1x;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    baud_clk_sel dut_i (
        .clk     (clk),
        .rst     (rst),
        .rx_sel  (rx_sel),
        .tx_sel  (tx_sel),
        .rx_ext  (rx_ext),
        .tx_ext  (tx_ext),
        .rx_tick (rx_tick),
        .tx_tick (tx_tick),
        .rx_1x   (rx_1x),
        .tx_1x   (tx_1x)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int baud_of(input int c);
        case (c)
            0: return 300;     1: return 600;     2: return 1200;
            3: return 2400;    4: return 4800;    5: return 9600;
            6: return 19200;   7: return 38400;   8: return 110;
            9: return 2000;    10: return 1800;   11: return 150;
            12: return 75;     default: return 50;
        endcase
    endfunction

    function automatic int div_of(input int c);
        int b;
        b = baud_of(c);
        return (230400 + b / 2) / b;
    endfunction

    function automatic string req_of(input int c);
        if (c == 5 || c == 7) return "R3";
        if (c == 8 || c == 9) return "R4";
        return "R2";
    endfunction

    // Internal rates on both directions at once.
    task automatic run_pair(input int crx, input int ctx);
        int drx, dtx, lim;
        int rt[3];
        int tt[3];
        int rn, tn, wide;
        bit prx, ptx;
        drx = div_of(crx);
        dtx = div_of(ctx);
        lim = 3 * ((drx > dtx) ? drx : dtx) + 10;
        rn = 0; tn = 0; wide = 0; prx = 0; ptx = 0;
        @(negedge clk);
        rx_sel = 4'(crx);
        tx_sel = 4'(ctx);
        for (int n = 1; n <= lim; n++) begin
            @(negedge clk);
            if (n >= 2) begin
                if (rx_tick && rn < 3) begin rt[rn] = n; rn++; end
                if (tx_tick && tn < 3) begin tt[tn] = n; tn++; end
                if ((rx_tick && prx) || (tx_tick && ptx)) wide++;
            end
            prx = rx_tick;
            ptx = tx_tick;
        end
        check(rn == 3, "R2 rx strobe count", rn, 3);
        check(tn == 3, "R10 tx strobe count", tn, 3);
        if (rn == 3) begin
            check(rt[0] == drx + 2, "R9 rx first strobe", rt[0], drx + 2);
            check(rt[1] - rt[0] == drx, req_of(crx), rt[1] - rt[0], drx);
            check(rt[2] - rt[1] == drx, req_of(crx), rt[2] - rt[1], drx);
        end
        if (tn == 3) begin
            check(tt[0] == dtx + 2, "R9 tx first strobe", tt[0], dtx + 2);
            check(tt[1] - tt[0] == dtx, {req_of(ctx), "/R10"}, tt[1] - tt[0], dtx);
            check(tt[2] - tt[1] == dtx, {req_of(ctx), "/R10"}, tt[2] - tt[1], dtx);
        end
        check(wide == 0, "R11 strobe width", wide, 0);
        check(rx_1x == 1'b0 && tx_1x == 1'b0, "R8 flags low internal",
              int'({rx_1x, tx_1x}), 0);
    endtask

    // Pin modes: rx pin rises every 8 cycles, tx pin every 12.
    task automatic pin_run(input int crx, input int ctx, input int nrx, input int ntx);
        int rc, tc, rfirst, tfirst, lim, wide;
        bit prx, ptx;
        rc = 0; tc = 0; rfirst = -1; tfirst = -1; wide = 0; prx = 0; ptx = 0;
        @(negedge clk);
        rx_sel = 4'(crx);
        tx_sel = 4'(ctx);
        rx_ext = 1'b0;
        tx_ext = 1'b0;
        repeat (6) @(negedge clk);
        check(rx_1x == (crx == 15), (crx == 15) ? "R6 rx flag" : "R5 rx flag",
              int'(rx_1x), int'(crx == 15));
        check(tx_1x == (ctx == 15), "R8 tx flag", int'(tx_1x), int'(ctx == 15));
        lim = ((nrx * 8 > ntx * 12) ? nrx * 8 : ntx * 12) + 10;
        for (int n = 0; n < lim; n++) begin
            @(negedge clk);
            if (rx_tick) begin rc++; if (rfirst < 0) rfirst = n; end
            if (tx_tick) begin tc++; if (tfirst < 0) tfirst = n; end
            if ((rx_tick && prx) || (tx_tick && ptx)) wide++;
            prx = rx_tick;
            ptx = tx_tick;
            rx_ext = (n < nrx * 8) ? (((n / 4) % 2) == 1) : 1'b0;
            tx_ext = (n < ntx * 12) ? (((n / 6) % 2) == 1) : 1'b0;
        end
        check(rc == nrx, (crx == 15) ? "R6 rx pin strobes" : "R5 rx pin strobes", rc, nrx);
        check(tc == ntx, "R7 tx pin strobes", tc, ntx);
        if (nrx > 0) check(rfirst == 7, "R5 rx pin latency", rfirst, 7);
        if (ntx > 0) check(tfirst == 9, "R7 tx pin latency", tfirst, 9);
        check(wide == 0, "R11 pin strobe width", wide, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything low, even with pin codes selected
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            if (n == 2) rx_ext = 1'b1;
            if (n >= 3) begin
                check(!rx_tick && !tx_tick, "R1 strobes in reset",
                      int'({rx_tick, tx_tick}), 0);
                check(!rx_1x && !tx_1x, "R1 flags in reset",
                      int'({rx_1x, tx_1x}), 0);
            end
        end
        rx_ext = 1'b0;
        rx_sel = 4'd0;
        tx_sel = 4'd0;
        rst = 1'b0;
        repeat (4) @(negedge clk);

        pin_run(14, 15, 5, 3);
        pin_run(15, 14, 4, 6);
        pin_run(14, 14, 5, 0);
        pin_run(15, 15, 0, 3);

        for (int c = 0; c < 14; c++) begin
            run_pair(c, 13 - c);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule